// File: doc/BRIEF.md
# Page Program Data Collector

This block sits behind the serial command decoder of a flash-style memory. It gathers the data bytes of one page-program command into a page-sized holding buffer. Once the chip select is released cleanly, it raises a one-cycle commit request toward the array write port. The decoder supplies four things: a start strobe with the 18-bit target address, a strobe for each completed data byte, a strobe when chip select goes high, and a flag that tells whether that release fell on a byte boundary.

The page is taken from the upper address bits and the starting byte offset from the low eight bits. Each received byte is stored at the current offset, which then advances and wraps within the page. A longer stream therefore leaves the most recent page's worth of bytes in the buffer. A per-byte valid mask records which offsets were written, so the write port, which can only clear bits by ANDing into the array, leaves the other bytes alone. A clean release after at least one byte issues the commit. A release in the middle of a byte, or one with no data, issues nothing. The buffer, mask and page stay in place until the next command starts, and the write port fetches bytes through a read port.

Top module: `pp_page_buffer`

## Requirements
- R1: After reset, commit_valid is 0 and commit_mask is all zeros.
- R2: A cmd_start strobe latches the page from cmd_addr[17:8] and the start offset from cmd_addr[7:0], and clears the mask. A byte strobe in the same cycle as cmd_start is not stored.
- R3: Each byte strobe during a command stores byte_data at the current offset, then the offset advances by one modulo 256. The page does not change.
- R4: When more than 256 bytes are received, the buffer holds the last 256 bytes received at their wrapped offsets, and the mask is all ones.
- R5: A cs_rise with cs_on_boundary=1 during a command with at least one byte stored gives commit_valid=1 for exactly one cycle, in the cycle after that strobe. commit_page and commit_mask describe the command.
- R6: A cs_rise with cs_on_boundary=0 ends the command without any commit.
- R7: A command ended with no data bytes issues no commit.
- R8: commit_mask bit i is 1 exactly when offset i received a byte in the current command.
- R9: A byte strobe in the same cycle as an aligned cs_rise is stored and counted in that commit.
- R10: Byte strobes and cs_rise outside a command are ignored. No commit occurs, and the mask and buffer are unchanged.
- R11: After a command ends, rd_data returns the stored byte at rd_ofs. Page, mask and buffer hold until the next cmd_start.
- R12: A cmd_start during a command restarts collection. Bytes from the abandoned command no longer appear in the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | Page-program command accepted, address valid |
| cmd_addr | input | 18 | Start address: page in the upper bits, offset in the low 8 |
| byte_valid | input | 1 | One complete data byte present on byte_data |
| byte_data | input | 8 | Data byte |
| cs_rise | input | 1 | Chip select went high |
| cs_on_boundary | input | 1 | The chip-select rise fell on a whole-byte boundary |
| commit_valid | output | 1 | One-cycle program request |
| commit_page | output | 10 | Page address of the request |
| commit_mask | output | 256 | Per-byte valid mask |
| rd_ofs | input | 8 | Buffer read offset |
| rd_data | output | 8 | Buffer byte at rd_ofs |

## Verification
The final data byte and the chip-select release can arrive in the same cycle. On odd-length runs the bench places the last byte strobe on the cs_rise cycle, and on even-length runs it sends the release alone. In both cases it expects the final offset in the mask and the commit one cycle later. The start strobe and a byte strobe are also made to coincide on every command. The bench checks that the stray byte appears neither in the mask nor at the start offset. The sweep runs every start offset against lengths from zero past twice the page size, on a 16-byte page.

// File: rtl/ppb_pkg.sv
package ppb_pkg;
    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_LOAD = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic  en;
        byte_t data;
    } beat_t;

    // a program request needs a clean release and at least one byte
    function automatic logic commit_ok(input logic on_boundary, input logic have_bytes);
        return on_boundary && have_bytes;
    endfunction
endpackage

// File: rtl/ppb_seq.sv
module ppb_seq
    import ppb_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int OFS_W  = 8,
    localparam int PAGE_W = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              byte_valid,
    input  logic              cs_rise,
    input  logic              cs_on_boundary,
    output logic              loading,
    output logic              wr_en,
    output logic [OFS_W-1:0]  wr_ofs,
    output logic              clr,
    output logic [PAGE_W-1:0] page,
    output logic              commit
);
    seq_state_e        st_q;
    logic [OFS_W-1:0]  ofs_q;
    logic [PAGE_W-1:0] page_q;
    logic              got_q;
    logic              commit_q;

    assign loading = (st_q == SEQ_LOAD);
    assign wr_en   = loading && byte_valid && !cmd_start;
    assign wr_ofs  = ofs_q;
    assign clr     = cmd_start;
    assign page    = page_q;
    assign commit  = commit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= SEQ_IDLE;
            ofs_q    <= '0;
            page_q   <= '0;
            got_q    <= 1'b0;
            commit_q <= 1'b0;
        end else begin
            commit_q <= 1'b0;
            if (cmd_start) begin
                st_q   <= SEQ_LOAD;
                ofs_q  <= cmd_addr[OFS_W-1:0];
                page_q <= cmd_addr[ADDR_W-1:OFS_W];
                got_q  <= 1'b0;
            end else if (loading) begin
                if (byte_valid) begin
                    ofs_q <= ofs_q + 1'b1;
                    got_q <= 1'b1;
                end
                if (cs_rise) begin
                    st_q     <= SEQ_IDLE;
                    commit_q <= commit_ok(cs_on_boundary, got_q || byte_valid);
                end
            end
        end
    end
endmodule

// File: rtl/ppb_store.sv
module ppb_store
    import ppb_pkg::*;
#(
    parameter int OFS_W = 8,
    localparam int NBYTES = 1 << OFS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  beat_t            beat,
    input  logic [OFS_W-1:0] wr_ofs,
    input  logic [OFS_W-1:0] rd_ofs,
    output logic [NBYTES-1:0] mask,
    output byte_t            rd_data
);
    byte_t             mem_q [NBYTES];
    logic [NBYTES-1:0] mask_q;

    always_ff @(posedge clk) begin
        if (beat.en) mem_q[wr_ofs] <= beat.data;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) mask_q <= '0;
        else if (beat.en) mask_q[wr_ofs] <= 1'b1;
    end

    assign mask    = mask_q;
    assign rd_data = mem_q[rd_ofs];
endmodule

// File: rtl/pp_page_buffer.sv
module pp_page_buffer
    import ppb_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int OFS_W  = 8,
    localparam int PAGE_W = ADDR_W - OFS_W,
    localparam int NBYTES = 1 << OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic              cs_rise,
    input  logic              cs_on_boundary,
    output logic              commit_valid,
    output logic [PAGE_W-1:0] commit_page,
    output logic [NBYTES-1:0] commit_mask,
    input  logic [OFS_W-1:0]  rd_ofs,
    output logic [BYTE_W-1:0] rd_data
);
    logic             loading;
    logic             wr_en;
    logic [OFS_W-1:0] wr_ofs;
    logic             clr;
    beat_t            beat;

    ppb_seq #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_seq (
        .clk            (clk),
        .rst            (rst),
        .cmd_start      (cmd_start),
        .cmd_addr       (cmd_addr),
        .byte_valid     (byte_valid),
        .cs_rise        (cs_rise),
        .cs_on_boundary (cs_on_boundary),
        .loading        (loading),
        .wr_en          (wr_en),
        .wr_ofs         (wr_ofs),
        .clr            (clr),
        .page           (commit_page),
        .commit         (commit_valid)
    );

    assign beat = '{en: wr_en, data: byte_data};

    ppb_store #(.OFS_W(OFS_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .beat    (beat),
        .wr_ofs  (wr_ofs),
        .rd_ofs  (rd_ofs),
        .mask    (commit_mask),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/ppb_checker.sv
module ppb_checker #(
    parameter int ADDR_W = 18,
    parameter int OFS_W  = 8,
    localparam int PAGE_W = ADDR_W - OFS_W,
    localparam int NBYTES = 1 << OFS_W
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_start,
    input logic              cs_rise,
    input logic              cs_on_boundary,
    input logic              loading,
    input logic              wr_en,
    input logic [OFS_W-1:0]  wr_ofs,
    input logic              commit_valid,
    input logic [PAGE_W-1:0] commit_page,
    input logic [NBYTES-1:0] commit_mask
);
    p_start_clears_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_start |=> (commit_mask == '0) && loading);

    p_byte_marks_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> commit_mask[$past(wr_ofs)]);

    p_single_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        commit_valid |=> !commit_valid);

    p_ragged_end_r6: assert property (@(posedge clk) disable iff (rst)
        (cs_rise && !cs_on_boundary && !cmd_start) |=> !commit_valid);

    p_nonempty_r7: assert property (@(posedge clk) disable iff (rst)
        commit_valid |-> (commit_mask != '0));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!loading && !cmd_start) |=> $stable(commit_mask));

    p_page_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !cmd_start |=> $stable(commit_page));
endmodule

bind pp_page_buffer ppb_checker #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) i_ppb_checker (
    .clk            (clk),
    .rst            (rst),
    .cmd_start      (cmd_start),
    .cs_rise        (cs_rise),
    .cs_on_boundary (cs_on_boundary),
    .loading        (loading),
    .wr_en          (wr_en),
    .wr_ofs         (wr_ofs),
    .commit_valid   (commit_valid),
    .commit_page    (commit_page),
    .commit_mask    (commit_mask)
);

// File: tb/test_pp_page_buffer.sv
module test_pp_page_buffer;
    localparam int AW = 8;
    localparam int OW = 4;
    localparam int NB = 1 << OW;
    localparam int PW = AW - OW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_start = 1'b0;
    logic [AW-1:0] cmd_addr = '0;
    logic          byte_valid = 1'b0;
    logic [7:0]    byte_data = '0;
    logic          cs_rise = 1'b0;
    logic          cs_on_boundary = 1'b0;
    logic [OW-1:0] rd_ofs = '0;
    logic          commit_valid;
    logic [PW-1:0] commit_page;
    logic [NB-1:0] commit_mask;
    logic [7:0]    rd_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [7:0]    exp_buf [NB];
    logic [NB-1:0] exp_mask = '0;

    always #2 clk = ~clk;

    pp_page_buffer #(.ADDR_W(AW), .OFS_W(OW)) i_pp_page_buffer (
        .clk(clk), .rst(rst), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
        .byte_valid(byte_valid), .byte_data(byte_data), .cs_rise(cs_rise),
        .cs_on_boundary(cs_on_boundary), .commit_valid(commit_valid),
        .commit_page(commit_page), .commit_mask(commit_mask),
        .rd_ofs(rd_ofs), .rd_data(rd_data)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_buffer(input string req);
        for (int i = 0; i < NB; i++) begin
            if (exp_mask[i]) begin
                rd_ofs = OW'(i);
                #1;
                chk(req, rd_data, exp_buf[i]);
            end
        end
    endtask

    task automatic run_cmd(input int page, input int ofs, input int len,
                           input bit aligned, input bit merge, input int seed);
        int off;
        logic [7:0] d;
        bit exp_commit;
        @(negedge clk);
        cmd_start = 1'b1; cmd_addr = AW'(page * NB + ofs);
        byte_valid = 1'b1; byte_data = 8'hA5;   // stray byte, must be dropped (R2)
        @(negedge clk);
        cmd_start = 1'b0; byte_valid = 1'b0;
        exp_mask = '0;
        for (int k = 0; k < len; k++) begin
            off = (ofs + k) % NB;
            d = 8'((seed * 7 + k * 13 + ofs) & 255);
            exp_buf[off] = d;
            exp_mask[off] = 1'b1;
            byte_valid = 1'b1; byte_data = d;
            if (merge && k == len - 1) begin
                cs_rise = 1'b1; cs_on_boundary = aligned;
            end
            @(negedge clk);
            byte_valid = 1'b0; cs_rise = 1'b0;
        end
        if (!(merge && len > 0)) begin
            cs_rise = 1'b1; cs_on_boundary = aligned;
            @(negedge clk);
            cs_rise = 1'b0;
        end
        exp_commit = aligned && (len > 0);
        chk(len == 0 ? "R7 no commit when empty" :
            !aligned ? "R6 ragged release" :
            merge ? "R9 byte on release cycle" : "R5 commit raised",
            commit_valid, exp_commit);
        if (exp_commit) begin
            chk("R2 page latched", commit_page, page);
            chk(len > NB ? "R4 mask full" : "R8 mask exact", commit_mask, exp_mask);
        end
        @(negedge clk);
        chk("R5 single pulse", commit_valid, 0);
        if (exp_commit) check_buffer(len > NB ? "R4 last bytes kept" : "R3 data at offset");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset commit", commit_valid, 0);
        chk("R1 reset mask", commit_mask, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", commit_valid, 0);

        for (int o = 0; o < NB; o++)
            for (int n = 0; n <= 2 * NB + 3; n++)
                run_cmd((o + n) % NB, o, n, 1'b1, n[0], o * 40 + n);

        for (int o = 0; o < NB; o++)
            for (int n = 0; n <= 5; n++)
                run_cmd(o, o, n, 1'b0, n[0], o + n);

        // R10 / R11: strobes while idle after a commit
        run_cmd(9, 5, 7, 1'b1, 1'b0, 3);
        repeat (4) @(negedge clk);
        byte_valid = 1'b1; byte_data = 8'h00;
        @(negedge clk);
        byte_valid = 1'b0;
        chk("R10 idle byte no commit", commit_valid, 0);
        cs_rise = 1'b1; cs_on_boundary = 1'b1;
        @(negedge clk);
        cs_rise = 1'b0;
        @(negedge clk);
        chk("R10 idle release no commit", commit_valid, 0);
        chk("R10 mask unchanged", commit_mask, exp_mask);
        chk("R11 page held", commit_page, 9);
        check_buffer("R11 buffer held");

        // R12: restart in the middle of a command
        @(negedge clk);
        cmd_start = 1'b1; cmd_addr = AW'(2 * NB + 3);
        @(negedge clk);
        cmd_start = 1'b0;
        for (int k = 0; k < 3; k++) begin
            byte_valid = 1'b1; byte_data = 8'(k + 1);
            @(negedge clk);
        end
        byte_valid = 1'b0;
        cmd_start = 1'b1; cmd_addr = AW'(5 * NB + 9);
        @(negedge clk);
        cmd_start = 1'b0;
        exp_mask = '0;
        for (int k = 0; k < 2; k++) begin
            byte_valid = 1'b1; byte_data = 8'(8'h30 + k);
            exp_buf[9 + k] = 8'(8'h30 + k);
            exp_mask[9 + k] = 1'b1;
            @(negedge clk);
        end
        byte_valid = 1'b0;
        cs_rise = 1'b1; cs_on_boundary = 1'b1;
        @(negedge clk);
        cs_rise = 1'b0;
        chk("R12 restart commit", commit_valid, 1);
        chk("R12 restart mask", commit_mask, exp_mask);
        chk("R12 restart page", commit_page, 5);
        check_buffer("R12 restart data");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule